// File: doc/BRIEF.md
# Per-Context Transaction State Table

This block keeps, for every hardware thread context of a core, a small record of whether that context is inside a hardware transaction and in which of two modes. In the "all" mode every memory access counts as speculative unless the instruction says otherwise. In the "select" mode accesses are ordinary unless the instruction asks for speculation. Each entry also holds a sticky exception flag. The flag is raised when the speculative line buffer reports that the context's transaction was killed. The thread keeps running after that, and the flag is delivered as an exception on the context's next memory access.

Each cycle the block takes at most one instruction event tagged with a context id, plus a mask of abort pulses from the line buffer. It returns registered responses one cycle later: whether an access may proceed and whether it is speculative, an exception-raise pulse, commit success or failure, and an error pulse for a nested begin. It also drives the current mode and flag of every context, so the line buffer can set or clear its per-context read and write vectors.

Top module: `txn_ctx_table`

## Requirements
- R1: After reset every context is idle with its flag clear, and all response pulses are low. Mode encoding on `mode_vec[2*i+1:2*i]`: 00 idle, 01 all mode, 10 select mode; 11 never occurs.
- R2: Opcode 1 (begin-all) or 2 (begin-select) on an idle context sets its mode to 01 or 10 by the next cycle and clears that context's exception flag.
- R3: In an active context, opcode 5 (plain access) is speculative only in all mode, opcode 6 (forced speculative) is always speculative, and opcode 7 (forced regular) is never speculative. `acc_fire` and `acc_spec` answer one cycle after the event, and `acc_wr` echoes `ev_wr` for a fired access.
- R4: An access (opcodes 5, 6, 7) from an idle context fires as non-speculative, even with opcode 6.
- R5: An abort pulse on `hw_abort[i]` while context i is active sets it idle and raises its flag. A pulse on an idle context is ignored: no flag is raised.
- R6: An access from a context whose flag is set gives `exc_raise` instead of `acc_fire`, and the flag is cleared once it has been delivered.
- R7: Opcode 3 (commit) always pulses `cmt_done`. `cmt_ok` is high only when the context was active with its flag clear, and success leaves the context idle. A commit with the flag set, or from an idle context, fails and leaves the flag unchanged.
- R8: A begin on a context that is already active is ignored (mode unchanged) and pulses `begin_err`.
- R9: Opcode 4 (abort instruction) sets the context idle without raising its flag and without any response pulse.
- R10: When an abort pulse and an event hit the same context in one cycle, the event sees the aborted state: a commit fails, an access raises the exception, and a begin is accepted. An abort pulse on a different context does not affect the event.
- R11: Every response pulse lasts exactly one cycle, and `rsp_ctx` gives the context id of the event that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Instruction event present this cycle |
| ev_ctx | input | CTX_W | Context id of the event |
| ev_op | input | 3 | Event opcode (0 none, 1 begin-all, 2 begin-select, 3 commit, 4 abort, 5 plain access, 6 forced speculative, 7 forced regular) |
| ev_wr | input | 1 | Access is a store |
| hw_abort | input | NUM_CTX | Per-context abort pulses from the line buffer |
| rsp_ctx | output | CTX_W | Context id the response refers to |
| acc_fire | output | 1 | Access may proceed |
| acc_spec | output | 1 | Fired access is speculative |
| acc_wr | output | 1 | Fired access is a store |
| exc_raise | output | 1 | Access replaced by an exception |
| cmt_done | output | 1 | Commit attempt finished |
| cmt_ok | output | 1 | Commit succeeded |
| begin_err | output | 1 | Begin issued in an active context |
| mode_vec | output | 2*NUM_CTX | Mode of every context |
| exc_vec | output | NUM_CTX | Exception flag of every context |

## Verification
The case that needs the most care is when a line-buffer abort pulse and an instruction event for the same context land in the same cycle. The abort must win: the event has to be judged against the idle, flagged state. The bench provokes this three ways, all against one active context: a commit, an access and a begin, each driven in the same cycle as a matching `hw_abort` bit. It expects a failed commit, an exception instead of an access, and an accepted begin. It also puts an abort pulse on a second context during an access, to show that the contexts do not disturb each other.

// File: rtl/txn_pkg.sv
// Package: shared opcode, mode and decode types for the transaction state table.
// Assumes: opcode values are fixed by the instruction decoder upstream.
package txn_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_ALL  = 2'b01,
        MODE_SEL  = 2'b10
    } txn_mode_e;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_BEGIN_ALL = 3'd1,
        OP_BEGIN_SEL = 3'd2,
        OP_COMMIT    = 3'd3,
        OP_ABORT     = 3'd4,
        OP_MEM       = 3'd5,
        OP_MEM_SPEC  = 3'd6,
        OP_MEM_NSPEC = 3'd7
    } txn_op_e;

    typedef enum logic [1:0] {
        OVR_NONE  = 2'd0,
        OVR_SPEC  = 2'd1,
        OVR_NSPEC = 2'd2
    } txn_ovr_e;

    typedef struct packed {
        logic      is_begin;
        txn_mode_e begin_mode;
        logic      is_commit;
        logic      is_abort;
        logic      is_mem;
        txn_ovr_e  ovr;
    } txn_dec_t;

endpackage

// File: rtl/txn_op_decode.sv
// Module: txn_op_decode
// Turns a raw event opcode into decoded control flags.
// Assumes: ev_valid low means no event; the output is then all zero.
module txn_op_decode
    import txn_pkg::*;
(
    input  logic     ev_valid,
    input  logic [2:0] ev_op,
    output txn_dec_t dec
);

    // Purpose: combinational opcode classification.
    always_comb begin
        dec = '0;
        dec.begin_mode = MODE_IDLE;
        dec.ovr        = OVR_NONE;
        if (ev_valid) begin
            unique case (txn_op_e'(ev_op))
                OP_BEGIN_ALL: begin
                    dec.is_begin   = 1'b1;
                    dec.begin_mode = MODE_ALL;
                end
                OP_BEGIN_SEL: begin
                    dec.is_begin   = 1'b1;
                    dec.begin_mode = MODE_SEL;
                end
                OP_COMMIT:    dec.is_commit = 1'b1;
                OP_ABORT:     dec.is_abort  = 1'b1;
                OP_MEM:       dec.is_mem    = 1'b1;
                OP_MEM_SPEC: begin
                    dec.is_mem = 1'b1;
                    dec.ovr    = OVR_SPEC;
                end
                OP_MEM_NSPEC: begin
                    dec.is_mem = 1'b1;
                    dec.ovr    = OVR_NSPEC;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/txn_ctx_entry.sv
// Module: txn_ctx_entry
// One table entry: the mode and the sticky exception flag of a single context.
// Assumes: the hardware abort pulse is applied before the event in the same
// cycle; view_* present that post-abort state to the response logic.
module txn_ctx_entry
    import txn_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  txn_dec_t  dec,
    input  logic      hw_abort,
    output txn_mode_e mode_q,
    output logic      flag_q,
    output txn_mode_e view_mode,
    output logic      view_flag
);

    logic live;
    logic killed;

    assign live      = (mode_q != MODE_IDLE);
    assign killed    = hw_abort && live;
    assign view_mode = killed ? MODE_IDLE : mode_q;
    assign view_flag = killed || flag_q;

    // Purpose: update mode and flag from abort pulse and this context's event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_IDLE;
            flag_q <= 1'b0;
        end else if (hit && dec.is_begin) begin
            if (view_mode == MODE_IDLE) begin
                mode_q <= dec.begin_mode;
                flag_q <= 1'b0;
            end else begin
                mode_q <= view_mode;
                flag_q <= view_flag;
            end
        end else if (hit && (dec.is_commit || dec.is_abort)) begin
            mode_q <= MODE_IDLE;
            flag_q <= view_flag;
        end else if (hit && dec.is_mem && view_flag) begin
            mode_q <= view_mode;
            flag_q <= 1'b0;
        end else begin
            mode_q <= view_mode;
            flag_q <= view_flag;
        end
    end

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != 2'b11); // R1

    AST_HW_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_abort && live && !hit) |=> (flag_q && mode_q == MODE_IDLE)); // R5

    AST_IDLE_ABORT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_abort && !live && !flag_q && !hit) |=> !flag_q); // R5

endmodule

// File: rtl/txn_access_qual.sv
// Module: txn_access_qual
// Combinational response for the addressed context: access qualification,
// exception delivery, commit outcome and nested-begin detection.
// Assumes: view_mode/view_flag already include a same-cycle abort pulse.
module txn_access_qual
    import txn_pkg::*;
(
    input  txn_dec_t  dec,
    input  txn_mode_e view_mode,
    input  logic      view_flag,
    input  logic      ev_wr,
    output logic      nx_acc,
    output logic      nx_spec,
    output logic      nx_wr,
    output logic      nx_exc,
    output logic      nx_cdone,
    output logic      nx_cok,
    output logic      nx_berr
);

    logic active;
    logic spec_by_mode;

    assign active = (view_mode != MODE_IDLE);

    // Purpose: pick speculation from override first, mode default second.
    always_comb begin
        unique case (dec.ovr)
            OVR_SPEC:  spec_by_mode = 1'b1;
            OVR_NSPEC: spec_by_mode = 1'b0;
            default:   spec_by_mode = (view_mode == MODE_ALL);
        endcase
    end

    // Purpose: form all next-cycle response pulses.
    always_comb begin
        nx_acc   = dec.is_mem && !view_flag;
        nx_exc   = dec.is_mem && view_flag;
        nx_spec  = nx_acc && active && spec_by_mode;
        nx_wr    = nx_acc && ev_wr;
        nx_cdone = dec.is_commit;
        nx_cok   = dec.is_commit && active && !view_flag;
        nx_berr  = dec.is_begin && active;
    end

endmodule

// File: rtl/txn_ctx_table.sv
// Module: txn_ctx_table (top)
// Per-context transaction state table: one entry per hardware context,
// an opcode decoder, a context selector and registered response pulses.
// Assumes: at most one instruction event per cycle; abort pulses may hit
// any set of contexts in the same cycle.
module txn_ctx_table
    import txn_pkg::*;
#(
    parameter int NUM_CTX = 4,
    localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_valid,
    input  logic [CTX_W-1:0]     ev_ctx,
    input  logic [2:0]           ev_op,
    input  logic                 ev_wr,
    input  logic [NUM_CTX-1:0]   hw_abort,
    output logic [CTX_W-1:0]     rsp_ctx,
    output logic                 acc_fire,
    output logic                 acc_spec,
    output logic                 acc_wr,
    output logic                 exc_raise,
    output logic                 cmt_done,
    output logic                 cmt_ok,
    output logic                 begin_err,
    output logic [2*NUM_CTX-1:0] mode_vec,
    output logic [NUM_CTX-1:0]   exc_vec
);

    localparam int SLOTS = 1 << CTX_W;

    txn_dec_t  dec;
    txn_mode_e mode_arr  [SLOTS];
    logic      flag_arr  [SLOTS];
    txn_mode_e vmode_arr [SLOTS];
    logic      vflag_arr [SLOTS];
    logic      abort_arr [SLOTS];

    txn_mode_e sel_mode;
    logic      sel_flag;
    logic nx_acc, nx_spec, nx_wr, nx_exc, nx_cdone, nx_cok, nx_berr;

    txn_op_decode u_dec (
        .ev_valid (ev_valid),
        .ev_op    (ev_op),
        .dec      (dec)
    );

    // One entry per real context; unused id slots read as idle.
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NUM_CTX) begin : g_real
            txn_ctx_entry u_entry (
                .clk       (clk),
                .rst_n     (rst_n),
                .hit       (ev_valid && (ev_ctx == CTX_W'(i))),
                .dec       (dec),
                .hw_abort  (hw_abort[i]),
                .mode_q    (mode_arr[i]),
                .flag_q    (flag_arr[i]),
                .view_mode (vmode_arr[i]),
                .view_flag (vflag_arr[i])
            );
            assign abort_arr[i]         = hw_abort[i];
            assign mode_vec[2*i +: 2]   = mode_arr[i];
            assign exc_vec[i]           = flag_arr[i];
        end else begin : g_pad
            assign mode_arr[i]  = MODE_IDLE;
            assign flag_arr[i]  = 1'b0;
            assign vmode_arr[i] = MODE_IDLE;
            assign vflag_arr[i] = 1'b0;
            assign abort_arr[i] = 1'b0;
        end
    end

    assign sel_mode = vmode_arr[ev_ctx];
    assign sel_flag = vflag_arr[ev_ctx];

    txn_access_qual u_qual (
        .dec       (dec),
        .view_mode (sel_mode),
        .view_flag (sel_flag),
        .ev_wr     (ev_wr),
        .nx_acc    (nx_acc),
        .nx_spec   (nx_spec),
        .nx_wr     (nx_wr),
        .nx_exc    (nx_exc),
        .nx_cdone  (nx_cdone),
        .nx_cok    (nx_cok),
        .nx_berr   (nx_berr)
    );

    // Purpose: register the response pulses and the context they refer to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ctx   <= '0;
            acc_fire  <= 1'b0;
            acc_spec  <= 1'b0;
            acc_wr    <= 1'b0;
            exc_raise <= 1'b0;
            cmt_done  <= 1'b0;
            cmt_ok    <= 1'b0;
            begin_err <= 1'b0;
        end else begin
            rsp_ctx   <= ev_ctx;
            acc_fire  <= nx_acc;
            acc_spec  <= nx_spec;
            acc_wr    <= nx_wr;
            exc_raise <= nx_exc;
            cmt_done  <= nx_cdone;
            cmt_ok    <= nx_cok;
            begin_err <= nx_berr;
        end
    end

    AST_EXC_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_raise && acc_fire)); // R6

    AST_FLAGGED_COMMIT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_op == 3'd3 && flag_arr[ev_ctx]) |=> (cmt_done && !cmt_ok)); // R7

    AST_IDLE_NONSPEC: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_op >= 3'd5 && mode_arr[ev_ctx] == MODE_IDLE) |=> !acc_spec); // R4

    AST_NESTED_BEGIN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && (ev_op == 3'd1 || ev_op == 3'd2) && mode_arr[ev_ctx] != MODE_IDLE
         && !abort_arr[ev_ctx]) |=> begin_err); // R8

endmodule

// File: tb/txn_ctx_table_tb.sv
`timescale 1ns/1ps
module txn_ctx_table_tb_top;

    localparam int NUM_CTX = 4;
    localparam int CTX_W   = 2;
    localparam int NV      = 30;

    // Vector layout: [18:17] ctx, [16:14] op, [13] wr, [12:9] abort mask,
    // [8] acc, [7] spec, [6] exc, [5] cdone, [4] cok, [3] berr,
    // [2:1] mode of ctx after, [0] flag of ctx after.
    localparam logic [18:0] VEC [NV] = '{
        {2'd0, 3'd5, 1'b0, 4'h0, 6'b100000, 2'd0, 1'b0}, // R4 idle plain
        {2'd0, 3'd6, 1'b0, 4'h0, 6'b100000, 2'd0, 1'b0}, // R4 idle forced spec
        {2'd0, 3'd1, 1'b0, 4'h0, 6'b000000, 2'd1, 1'b0}, // R2 begin-all
        {2'd0, 3'd5, 1'b1, 4'h0, 6'b110000, 2'd1, 1'b0}, // R3 all plain store
        {2'd0, 3'd7, 1'b0, 4'h0, 6'b100000, 2'd1, 1'b0}, // R3 forced regular
        {2'd1, 3'd2, 1'b0, 4'h0, 6'b000000, 2'd2, 1'b0}, // R2 begin-select
        {2'd1, 3'd5, 1'b0, 4'h0, 6'b100000, 2'd2, 1'b0}, // R3 select plain
        {2'd1, 3'd6, 1'b0, 4'h0, 6'b110000, 2'd2, 1'b0}, // R3 select forced spec
        {2'd0, 3'd1, 1'b0, 4'h0, 6'b000001, 2'd1, 1'b0}, // R8 nested begin
        {2'd0, 3'd3, 1'b0, 4'h0, 6'b000110, 2'd0, 1'b0}, // R7 commit ok
        {2'd1, 3'd0, 1'b0, 4'h2, 6'b000000, 2'd0, 1'b1}, // R5 abort pulse active
        {2'd1, 3'd5, 1'b0, 4'h0, 6'b001000, 2'd0, 1'b0}, // R6 exception delivered
        {2'd1, 3'd5, 1'b0, 4'h0, 6'b100000, 2'd0, 1'b0}, // R6 flag cleared
        {2'd2, 3'd0, 1'b0, 4'h4, 6'b000000, 2'd0, 1'b0}, // R5 pulse on idle ignored
        {2'd2, 3'd2, 1'b0, 4'h0, 6'b000000, 2'd2, 1'b0}, // R2
        {2'd2, 3'd4, 1'b0, 4'h0, 6'b000000, 2'd0, 1'b0}, // R9 abort instruction
        {2'd2, 3'd3, 1'b0, 4'h0, 6'b000100, 2'd0, 1'b0}, // R7 commit idle fails
        {2'd3, 3'd1, 1'b0, 4'h0, 6'b000000, 2'd1, 1'b0}, // R2
        {2'd3, 3'd3, 1'b0, 4'h8, 6'b000100, 2'd0, 1'b1}, // R10 commit + abort
        {2'd3, 3'd1, 1'b0, 4'h0, 6'b000000, 2'd1, 1'b0}, // R2 begin clears flag
        {2'd3, 3'd5, 1'b0, 4'h8, 6'b001000, 2'd0, 1'b0}, // R10 access + abort
        {2'd3, 3'd1, 1'b0, 4'h0, 6'b000000, 2'd1, 1'b0}, // R2
        {2'd3, 3'd3, 1'b0, 4'h0, 6'b000110, 2'd0, 1'b0}, // R7 commit ok
        {2'd1, 3'd2, 1'b0, 4'h0, 6'b000000, 2'd2, 1'b0}, // R2
        {2'd0, 3'd1, 1'b0, 4'h0, 6'b000000, 2'd1, 1'b0}, // R2
        {2'd0, 3'd5, 1'b0, 4'h2, 6'b110000, 2'd1, 1'b0}, // R10 other ctx aborted
        {2'd1, 3'd1, 1'b0, 4'h0, 6'b000000, 2'd1, 1'b0}, // R2 flagged ctx begins
        {2'd1, 3'd0, 1'b0, 4'h2, 6'b000000, 2'd0, 1'b1}, // R5
        {2'd1, 3'd3, 1'b0, 4'h0, 6'b000100, 2'd0, 1'b1}, // R7 flagged commit fails
        {2'd1, 3'd3, 1'b0, 4'h2, 6'b000100, 2'd0, 1'b1}  // R10 begin-less abort idle
    };
    localparam int REQ [NV] = '{4,4,2,3,3,2,3,3,8,7,5,6,6,5,2,9,7,2,10,2,10,2,7,2,2,10,2,5,7,10};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 ev_valid = 1'b0;
    logic [CTX_W-1:0]     ev_ctx = '0;
    logic [2:0]           ev_op = '0;
    logic                 ev_wr = 1'b0;
    logic [NUM_CTX-1:0]   hw_abort = '0;
    logic [CTX_W-1:0]     rsp_ctx;
    logic acc_fire, acc_spec, acc_wr, exc_raise, cmt_done, cmt_ok, begin_err;
    logic [2*NUM_CTX-1:0] mode_vec;
    logic [NUM_CTX-1:0]   exc_vec;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    txn_ctx_table #(.NUM_CTX(NUM_CTX)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ctx(ev_ctx),
        .ev_op(ev_op), .ev_wr(ev_wr), .hw_abort(hw_abort), .rsp_ctx(rsp_ctx),
        .acc_fire(acc_fire), .acc_spec(acc_spec), .acc_wr(acc_wr),
        .exc_raise(exc_raise), .cmt_done(cmt_done), .cmt_ok(cmt_ok),
        .begin_err(begin_err), .mode_vec(mode_vec), .exc_vec(exc_vec)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; the response is sampled at the next falling edge.
    task automatic apply(input int c, input int op, input bit wr, input logic [3:0] abt);
        ev_valid = 1'b1;
        ev_ctx   = CTX_W'(c);
        ev_op    = 3'(op);
        ev_wr    = wr;
        hw_abort = abt;
        @(negedge clk);
    endtask

    task automatic idle_cycle();
        ev_valid = 1'b0;
        ev_op    = 3'd0;
        hw_abort = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check({acc_fire, acc_spec, acc_wr, exc_raise, cmt_done, cmt_ok, begin_err} == 7'd0
              && mode_vec == '0 && exc_vec == '0, "R1 reset outputs",
              {acc_fire, acc_spec, exc_raise, cmt_done, cmt_ok, begin_err, mode_vec}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            logic [18:0] v;
            int c;
            logic [9:0] act, exp;
            v = VEC[k];
            c = int'(v[18:17]);
            apply(c, int'(v[16:14]), v[13], v[12:9]);
            act = {acc_fire, acc_spec, acc_wr, exc_raise, cmt_done, cmt_ok, begin_err,
                   mode_vec[2*c +: 2], exc_vec[c]};
            exp = {v[8], v[7], v[8] & v[13], v[6], v[5], v[4], v[3], v[2:1], v[0]};
            check(act == exp, $sformatf("R%0d vector %0d", REQ[k], k), int'(act), int'(exp));
            if (v[8:3] != 6'd0)
                check(rsp_ctx == CTX_W'(c), "R11 response context", int'(rsp_ctx), c);
        end

        // R11: pulses last one cycle
        idle_cycle();
        check({acc_fire, exc_raise, cmt_done, cmt_ok, begin_err} == 5'd0, "R11 pulse width",
              {acc_fire, exc_raise, cmt_done, cmt_ok, begin_err}, 0);

        // R1: reset in mid-transaction returns all contexts to idle
        apply(2, 1, 1'b0, 4'h0);
        check(mode_vec[5:4] == 2'b01, "R1 begin before reset", int'(mode_vec[5:4]), 1);
        ev_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(mode_vec == '0 && exc_vec == '0, "R1 reset clears table",
              int'({mode_vec, exc_vec}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: abort on same ctx during begin -> begin accepted
        apply(1, 2, 1'b0, 4'h0);
        apply(1, 1, 1'b0, 4'h2);
        check(!begin_err && mode_vec[3:2] == 2'b01 && !exc_vec[1], "R10 begin + abort",
              int'({begin_err, mode_vec[3:2], exc_vec[1]}), 2);
        idle_cycle();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule